// File: doc/BRIEF.md
# BT.656 Stream Timing Decoder

This block watches an 8-bit ITU-R BT.656 style byte stream and recovers the raster timing from the embedded four-byte timing references. Each reference is a three-byte preamble followed by a status byte that carries the field, vertical-blanking and horizontal-blanking bits and four protection bits. The decoder recomputes the protection bits. It keeps the field, vblank and hblank flags only from codes that check out, and it raises a one-cycle error flag for any code that does not.

Between a start-of-active-video code and the end of the line, the block demultiplexes the interleaved chroma/luma byte stream into aligned Y, Cb and Cr outputs. It gives one strobe per luma sample, and each chroma pair is held across the two luma samples that share it. A control input swaps which chroma component is expected first. The block also emits a line-start pulse on every valid start code and a frame-start pulse where vertical blanking ends.

Top module: `bt656_stream_decoder`

## Requirements
- R1: While reset is held and directly after it, smp_valid, line_start, frame_start and prot_err are 0, field is 0 and both vblank and hblank are 1.
- R2: A byte sequence FFh, 00h, 00h, S whose status byte S passes the check of R3 updates field to S[6], vblank to S[5] and hblank to S[4] on the clock edge that samples S.
- R3: A status byte is valid only if S[7] is 1 and S[3:0] equals {V^H, F^H, F^V, F^V^H}, with F=S[6], V=S[5], H=S[4]. An invalid status byte after the preamble sets prot_err for exactly one cycle. That code leaves field, vblank and hblank unchanged, gives no line or frame pulse and starts no samples.
- R4: A valid code with H=1 (end of active video) sets hblank. A valid code with H=0 (start of active video) clears hblank.
- R5: line_start pulses for one cycle on every valid code with H=0, in the same cycle the flags update.
- R6: frame_start pulses together with line_start when a valid H=0 code carries V=0 and the previous valid H=0 code carried V=1.
- R7: After a valid H=0 code with V=0, the following bytes are taken as repeating groups of first chroma, Y, second chroma, Y. The first Y of a group appears on y_out with smp_valid one cycle after the second chroma byte is sampled. The second Y appears in the next cycle. cb_out and cr_out hold the group's chroma for both strobes.
- R8: With chroma_swap at 0, the first chroma byte of each group is Cb. With chroma_swap at 1, the first is Cr and the second is Cb.
- R9: Each active line gives exactly LUMA (default 720) strobes. A valid H=0 code with V=1 starts no strobes.
- R10: Bytes not preceded by the exact preamble, such as blanking fill 80h/10h or a short FFh, 00h run, change no flag and raise no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | 8 | Incoming stream byte |
| chroma_swap | input | 1 | 1: Cr precedes Cb in each group |
| y_out | output | 8 | Luma sample |
| cb_out | output | 8 | Blue-difference chroma of the current pair |
| cr_out | output | 8 | Red-difference chroma of the current pair |
| smp_valid | output | 1 | One strobe per luma sample |
| line_start | output | 1 | Pulse on a valid start-of-active code |
| frame_start | output | 1 | Pulse where vertical blanking ends |
| field | output | 1 | Field bit from the last valid code |
| vblank | output | 1 | Vertical blanking bit from the last valid code |
| hblank | output | 1 | High between end and start codes |
| prot_err | output | 1 | One-cycle flag for a code that fails protection |

## Verification
The bound checker watches every cycle for the following. A protection error must leave the flags frozen and arrive without any line or frame pulse. A frame start must coincide with a line start out of vertical blanking. Samples may occur only inside unblanked lines, and no line may produce more than LUMA strobes. The scoreboard scenarios cover the remaining behaviour: the exact values and alignment of Y with its chroma pair, the effect of the swap control, the exact strobe count per line, the field and vblank values carried by each code, and the immunity to blanking fill and near-miss preambles.

// File: rtl/bt656_pkg.sv
package bt656_pkg;

  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned PRE_LEN = 3;

  typedef struct packed {
    logic f;
    logic v;
    logic h;
  } tref_t;

  // Preamble byte expected i positions before the status byte (i=0 nearest)
  function automatic logic [BYTE_W-1:0] preamble_byte(input int unsigned i);
    return (i == PRE_LEN - 1) ? 8'hFF : 8'h00;
  endfunction

  function automatic logic [3:0] prot_calc(input logic f, input logic v, input logic h);
    return {v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  function automatic logic status_ok(input logic [BYTE_W-1:0] s);
    return s[7] && (s[3:0] == prot_calc(s[6], s[5], s[4]));
  endfunction

  function automatic tref_t status_fields(input logic [BYTE_W-1:0] s);
    tref_t t;
    t.f = s[6];
    t.v = s[5];
    t.h = s[4];
    return t;
  endfunction

endpackage

// File: rtl/ref_hunter.sv
module ref_hunter
  import bt656_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] din,
  output logic              code_good,
  output logic              code_bad,
  output tref_t             code
);

  logic [BYTE_W-1:0] hist [PRE_LEN];
  logic [PRE_LEN-1:0] match;

  genvar gi;
  generate
    for (gi = 0; gi < PRE_LEN; gi++) begin : g_hist
      always_ff @(posedge clk) begin
        if (!rst_n) hist[gi] <= 8'h80;
        else if (gi == 0) hist[gi] <= din;
        else hist[gi] <= hist[gi-1];
      end
      assign match[gi] = (hist[gi] == preamble_byte(gi));
    end
  endgenerate

  logic preamble_hit;
  assign preamble_hit = &match;
  assign code_good    = preamble_hit && status_ok(din);
  assign code_bad     = preamble_hit && !status_ok(din);
  assign code         = status_fields(din);

endmodule

// File: rtl/timing_tracker.sv
module timing_tracker
  import bt656_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  code_good,
  input  logic  code_bad,
  input  tref_t code,
  output logic  act_start,
  output logic  field,
  output logic  vblank,
  output logic  hblank,
  output logic  line_start,
  output logic  frame_start,
  output logic  prot_err
);

  logic last_sav_v;
  logic sav_seen;
  assign sav_seen  = code_good && !code.h;
  assign act_start = sav_seen && !code.v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      field       <= 1'b0;
      vblank      <= 1'b1;
      hblank      <= 1'b1;
      line_start  <= 1'b0;
      frame_start <= 1'b0;
      prot_err    <= 1'b0;
      last_sav_v  <= 1'b0;
    end else begin
      prot_err    <= code_bad;
      line_start  <= sav_seen;
      frame_start <= sav_seen && last_sav_v && !code.v;
      if (code_good) begin
        field  <= code.f;
        vblank <= code.v;
        hblank <= code.h;
      end
      if (sav_seen) last_sav_v <= code.v;
    end
  end

endmodule

// File: rtl/sample_demux.sv
module sample_demux
  import bt656_pkg::*;
#(
  parameter int unsigned LUMA = 720
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] din,
  input  logic              act_start,
  input  logic              chroma_swap,
  output logic [BYTE_W-1:0] y_out,
  output logic [BYTE_W-1:0] cb_out,
  output logic [BYTE_W-1:0] cr_out,
  output logic              smp_valid
);

  localparam int unsigned BYTES = 2 * LUMA;
  localparam int unsigned IDX_W = $clog2(BYTES + 1);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(BYTES - 1);

  logic              active;
  logic [IDX_W-1:0]  idx;
  logic [BYTE_W-1:0] chroma_a;
  logic [BYTE_W-1:0] y_hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      idx       <= '0;
      chroma_a  <= '0;
      y_hold    <= '0;
      y_out     <= '0;
      cb_out    <= '0;
      cr_out    <= '0;
      smp_valid <= 1'b0;
    end else if (act_start) begin
      active    <= 1'b1;
      idx       <= '0;
      smp_valid <= 1'b0;
    end else if (active) begin
      idx <= idx + 1'b1;
      if (idx == LAST) active <= 1'b0;
      unique case (idx[1:0])
        2'd0: begin chroma_a <= din; smp_valid <= 1'b0; end
        2'd1: begin y_hold   <= din; smp_valid <= 1'b0; end
        2'd2: begin
          y_out     <= y_hold;
          cb_out    <= chroma_swap ? din : chroma_a;
          cr_out    <= chroma_swap ? chroma_a : din;
          smp_valid <= 1'b1;
        end
        default: begin
          y_out     <= din;
          smp_valid <= 1'b1;
        end
      endcase
    end else begin
      smp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/bt656_stream_decoder.sv
module bt656_stream_decoder
  import bt656_pkg::*;
#(
  parameter int unsigned LUMA = 720
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] din,
  input  logic       chroma_swap,
  output logic [7:0] y_out,
  output logic [7:0] cb_out,
  output logic [7:0] cr_out,
  output logic       smp_valid,
  output logic       line_start,
  output logic       frame_start,
  output logic       field,
  output logic       vblank,
  output logic       hblank,
  output logic       prot_err
);

  logic  code_good;
  logic  code_bad;
  tref_t code;
  logic  act_start;

  ref_hunter u_hunt (
    .clk(clk), .rst_n(rst_n), .din(din),
    .code_good(code_good), .code_bad(code_bad), .code(code)
  );

  timing_tracker u_trk (
    .clk(clk), .rst_n(rst_n), .code_good(code_good), .code_bad(code_bad),
    .code(code), .act_start(act_start), .field(field), .vblank(vblank),
    .hblank(hblank), .line_start(line_start), .frame_start(frame_start),
    .prot_err(prot_err)
  );

  sample_demux #(.LUMA(LUMA)) u_dmx (
    .clk(clk), .rst_n(rst_n), .din(din), .act_start(act_start),
    .chroma_swap(chroma_swap), .y_out(y_out), .cb_out(cb_out),
    .cr_out(cr_out), .smp_valid(smp_valid)
  );

endmodule

// File: rtl/bt656_stream_decoder_chk.sv
module bt656_stream_decoder_chk #(
  parameter int unsigned LUMA = 720
) (
  input logic clk,
  input logic rst_n,
  input logic smp_valid,
  input logic line_start,
  input logic frame_start,
  input logic field,
  input logic vblank,
  input logic hblank,
  input logic prot_err
);

  localparam int unsigned CW = $clog2(LUMA + 2);
  logic [CW-1:0] strobe_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) strobe_cnt <= '0;
    else if (line_start) strobe_cnt <= '0;
    else if (smp_valid && strobe_cnt <= CW'(LUMA)) strobe_cnt <= strobe_cnt + 1'b1;
  end

  // R3
  err_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot_err |-> (!line_start && !frame_start));

  // R3
  err_flags_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot_err |-> ($stable(field) && $stable(vblank) && $stable(hblank)));

  // R5
  line_start_unblanked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |-> !hblank);

  // R5
  line_start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> !line_start);

  // R6
  frame_with_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (line_start && !vblank));

  // R9
  samples_in_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> (!hblank && !vblank));

  // R9
  strobe_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_cnt <= CW'(LUMA));

endmodule

bind bt656_stream_decoder bt656_stream_decoder_chk #(.LUMA(LUMA)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .line_start(line_start),
  .frame_start(frame_start), .field(field), .vblank(vblank), .hblank(hblank),
  .prot_err(prot_err)
);

// File: tb/tb_bt656_stream_decoder.sv
module tb_bt656_stream_decoder;

  localparam int LUMA = 720;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] din = 8'h80;
  logic       chroma_swap = 1'b0;
  logic [7:0] y_out, cb_out, cr_out;
  logic       smp_valid, line_start, frame_start, field, vblank, hblank, prot_err;

  always #4 clk = ~clk;

  bt656_stream_decoder #(.LUMA(LUMA)) dut (
    .clk(clk), .rst_n(rst_n), .din(din), .chroma_swap(chroma_swap),
    .y_out(y_out), .cb_out(cb_out), .cr_out(cr_out), .smp_valid(smp_valid),
    .line_start(line_start), .frame_start(frame_start), .field(field),
    .vblank(vblank), .hblank(hblank), .prot_err(prot_err)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [23:0] expq [$];
  int strobes = 0;

  logic exp_f = 0, exp_v = 1, exp_h = 1, prev_sav_v = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: scoreboard pop
  always @(negedge clk) begin
    if (rst_n && smp_valid) begin
      strobes++;
      if (expq.size() == 0) check("R9 unexpected strobe", {8'h0, y_out, cb_out, cr_out}, 32'hFFFFFFFF);
      else check("R7/R8 sample", {8'h0, y_out, cb_out, cr_out}, {8'h0, expq.pop_front()});
    end
  end

  task automatic put(input logic [7:0] b);
    din = b;
    @(negedge clk);
  endtask

  function automatic logic [7:0] make_xy(input logic f, input logic v, input logic h);
    logic [7:0] s;
    s[7] = 1'b1; s[6] = f; s[5] = v; s[4] = h;
    s[3] = (v != h);
    s[2] = (f != h);
    s[1] = (f != v);
    s[0] = ((f + v + h) % 2) == 1;
    return s;
  endfunction

  // sends a reference code; corrupt: 0 none, 1 flip P0, 2 clear bit 7
  task automatic send_code(input logic f, input logic v, input logic h, input int corrupt);
    logic [7:0] s;
    s = make_xy(f, v, h);
    if (corrupt == 1) s[0] = ~s[0];
    if (corrupt == 2) s[7] = 1'b0;
    put(8'hFF); put(8'h00); put(8'h00); put(s);
    if (corrupt == 0) begin
      check("R2 field", field, f);
      check("R2 vblank", vblank, v);
      check("R4 hblank", hblank, h);
      check("R3 no error on good code", prot_err, 0);
      check("R5 line_start", line_start, !h);
      check("R6 frame_start", frame_start, (!h && prev_sav_v && !v));
      exp_f = f; exp_v = v; exp_h = h;
      if (!h) prev_sav_v = v;
    end else begin
      check("R3 prot_err", prot_err, 1);
      check("R3 flags kept", {field, vblank, hblank}, {exp_f, exp_v, exp_h});
      check("R3 no pulses", {line_start, frame_start}, 0);
    end
  endtask

  task automatic blank_fill(input int pairs);
    for (int i = 0; i < pairs; i++) begin put(8'h80); put(8'h10); end
  endtask

  task automatic send_line(input logic f, input logic v, input logic swap, input int seed);
    logic [7:0] cb, cr, y0, y1;
    chroma_swap = swap;
    send_code(f, v, 1'b1, 0);
    blank_fill(8);
    check("R4 hblank during fill", hblank, 1);
    send_code(f, v, 1'b0, 0);
    strobes = 0;
    for (int g = 0; g < LUMA / 2; g++) begin
      cb = 8'((seed + g * 3) % 250 + 2);
      cr = 8'((seed * 5 + g * 7) % 250 + 2);
      y0 = 8'((seed + g * 11) % 250 + 3);
      y1 = 8'((seed * 3 + g * 13) % 250 + 1);
      if (v) begin
        blank_fill(2);
      end else begin
        expq.push_back({y0, cb, cr});
        expq.push_back({y1, cb, cr});
        put(swap ? cr : cb); put(y0); put(swap ? cb : cr); put(y1);
      end
    end
    blank_fill(1);
    check("R9 strobes per line", strobes, v ? 0 : LUMA);
    check("R9 queue drained", expq.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (smp_valid || line_start || frame_start || prot_err || field || !vblank || !hblank) begin
      failures++;
      $display("FAIL R1 reset state actual=%b expected=0000011",
               {smp_valid, line_start, frame_start, prot_err, field, vblank, hblank});
    end
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {smp_valid, line_start, frame_start, prot_err, field, vblank, hblank}, 7'b0000011);

    // R10: near-miss preamble and blanking fill
    put(8'hFF); put(8'h00); put(make_xy(1, 0, 0));
    check("R10 short preamble ignored", {field, vblank, hblank, line_start, prot_err}, 5'b01100);
    blank_fill(4);
    check("R10 fill ignored", {field, vblank, hblank}, 3'b011);

    send_line(0, 1, 0, 1);   // blanked line: R9 no strobes, no frame start
    send_line(0, 0, 0, 7);   // first active: R6 frame start, R7 samples
    send_line(0, 0, 0, 19);  // no frame start
    send_line(0, 0, 1, 33);  // R8 swapped chroma

    send_code(1, 1, 1, 1);   // R3 bad P0
    send_code(1, 0, 0, 2);   // R3 bit 7 clear
    blank_fill(4);
    check("R3 bad SAV starts no samples", strobes, LUMA);

    send_line(1, 1, 0, 4);   // field 1 blanking
    send_line(1, 0, 1, 55);  // field 1 active, R6 frame start again, R2 field=1
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule